// File: doc/BRIEF.md
# Stacked Memory Chip-Select Router

This block sits between a word-addressed host request port and a parallel bus shared by two flash dies and one pseudo-static RAM. It takes one request at a time through a request/acknowledge handshake, decodes the word address to exactly one device, and drives registered active-low chip enables, output enables and a write strobe. Because only one request is in flight, operations on the two flash dies can never overlap.

Burst reads run word by word. Each word is paced by the shared WAIT line. When a burst would step from the last word of one device into the next device, the block ends the access, leaves every enable deasserted for one cycle, and resumes on the next device. The host sees one acknowledge at the end. Two-cycle flash commands are guarded: once a setup code has gone to one die, a second cycle aimed at the other die is refused with an error and never reaches the bus.

The flash dies and the RAM come out of reset with opposite WAIT polarities. The block follows configuration writes to learn each device's polarity. It turns the raw WAIT line into one active-high ready for the host and flags any polarity disagreement. A single flash reset output drives both dies.

Top module: `memsel_router`

## Requirements
- R1: Host address bit 22 high selects the RAM (`ram_ce_n`). With bit 22 low, bit 21 picks the flash die: 0 gives `fl_ce_n[0]`/`fl_oe_n[0]`, 1 gives `fl_ce_n[1]`/`fl_oe_n[1]`. The enable goes low in the cycle after the request is accepted.
- R2: At most one of `fl_ce_n[0]`, `fl_ce_n[1]`, `ram_ce_n` is low in any cycle.
- R3: A write holds the device enable and `bus_we_n` low for exactly one cycle, with output enables high. A read holds the device's chip and output enables low with `bus_we_n` high. `host_ack` pulses for one cycle after the last bus cycle. A read length of 0 is treated as 1 word.
- R4: A burst read whose next word lies on another device ends on the current device and leaves all chip enables high for one cycle. It then continues on the next device; after the RAM's top word it wraps to flash die 0. `bus_addr` carries the low 22 address bits of the current word, and a single `host_ack` comes after the final word.
- R5: A flash write whose low data byte is 0x40 or 0x20 arms a pending command for that die. The next plain flash write clears the pending state. If that write targets the other die, it gets no bus cycle, and `host_ack` comes with `host_err` high.
- R6: A write with `host_cfg` high is issued as a bus write with `bus_cfg` high. It also loads data bit 10 as the addressed device's WAIT polarity, where 1 means WAIT is asserted high. After reset the flash dies hold 0 and the RAM holds 1.
- R7: `cfg_mismatch` is high whenever either flash die's polarity differs from the RAM's polarity, including straight after reset.
- R8: During a read, `host_ready` and `host_beat` are high exactly when `bus_wait` differs from the active device's polarity. Each such cycle transfers one word.
- R9: Outside read data cycles `host_ready` is high and `host_beat` low, whatever `bus_wait` does.
- R10: While reset is applied, `fl_rst_n` is low and all enables and `bus_we_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_cfg | input | 1 | Write targets the device's configuration register |
| host_addr | input | 23 | Word address |
| host_len | input | 6 | Read length in words (0 means 1) |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Request refused, valid with host_ack |
| host_beat | output | 1 | One read word transferred this cycle |
| host_ready | output | 1 | Normalised active-high ready |
| cfg_mismatch | output | 1 | Flash and RAM WAIT polarities disagree |
| fl_ce_n | output | 2 | Flash die chip enables, active low |
| fl_oe_n | output | 2 | Flash die output enables, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| bus_we_n | output | 1 | Shared write strobe, active low |
| bus_cfg | output | 1 | Current write is a configuration write |
| bus_addr | output | 22 | Device word address |
| bus_wdata | output | 16 | Write data on the bus |
| bus_wait | input | 1 | Raw shared WAIT line |
| fl_rst_n | output | 1 | Reset to both flash dies, active low |

## Verification
The bench targets bursts that start a few words below the die 0/die 1 edge, the flash/RAM edge and the top of the address space. A design without the idle cycle would drive two enables back to back, and one that missed the crossing would keep reading past the end of a die. Mixed-die command pairs check that a stray second cycle never reaches the bus and that the pending state is released afterwards. WAIT is toggled randomly through every phase while the polarity bits change between reads: an inverted or stale polarity shows up as a wrong ready or beat count, and a design that looks at WAIT outside reads loses ready during writes.

// File: rtl/memsel_pkg.sv
`timescale 1ns/1ps
package memsel_pkg;

    localparam int NDEV = 3;

    typedef enum logic [1:0] {
        DEV_F1   = 2'd0,
        DEV_F2   = 2'd1,
        DEV_RAM  = 2'd2,
        DEV_NONE = 2'd3
    } dev_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_GAP  = 2'd2
    } st_e;

    function automatic logic [NDEV-1:0] dev_onehot(dev_e d);
        case (d)
            DEV_F1:  return 3'b001;
            DEV_F2:  return 3'b010;
            DEV_RAM: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/memsel_decode.sv
`timescale 1ns/1ps
module memsel_decode
    import memsel_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic [AW-1:0] addr,
    output dev_e          dev
);
    localparam int RAM_BIT = AW - 1;
    localparam int DIE_BIT = AW - 2;

    always_comb begin
        if (addr[RAM_BIT])      dev = DEV_RAM;
        else if (addr[DIE_BIT]) dev = DEV_F2;
        else                    dev = DEV_F1;
    end
endmodule

// File: rtl/memsel_cmd_guard.sv
`timescale 1ns/1ps
module memsel_cmd_guard #(
    parameter int          CW      = 8,
    parameter logic [CW-1:0] SETUP_A = 8'h40,
    parameter logic [CW-1:0] SETUP_B = 8'h20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fl_wr,
    input  logic          die,
    input  logic [CW-1:0] code,
    output logic          reject
);
    typedef struct packed {
        logic armed;
        logic die;
    } guard_t;

    guard_t guard_d, guard_q;

    always_comb begin
        guard_d = guard_q;
        reject  = guard_q.armed && (die != guard_q.die);
        if (fl_wr) begin
            if (guard_q.armed) begin
                guard_d.armed = 1'b0;
            end else if (code == SETUP_A || code == SETUP_B) begin
                guard_d.armed = 1'b1;
                guard_d.die   = die;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) guard_q <= '0;
        else     guard_q <= guard_d;
    end

    // R5: a refused cycle always releases the pending command
    a_r5_reject_clears: assert property (@(posedge clk) disable iff (rst)
        (fl_wr && reject) |=> !guard_q.armed);

    // R5: a plain write never arms when already armed
    a_r5_second_disarms: assert property (@(posedge clk) disable iff (rst)
        (fl_wr && guard_q.armed) |=> !guard_q.armed);
endmodule

// File: rtl/memsel_wait_norm.sv
`timescale 1ns/1ps
module memsel_wait_norm
    import memsel_pkg::*;
#(
    parameter logic [NDEV-1:0] RST_POL = 3'b100
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  dev_e cfg_dev,
    input  logic cfg_bit,
    input  dev_e act_dev,
    input  logic bus_wait,
    output logic ready,
    output logic mismatch
);
    localparam int RAM_IDX = NDEV - 1;

    typedef struct packed {
        logic [NDEV-1:0] pol;
    } pol_t;

    pol_t pol_d, pol_q;
    logic sel_pol;

    always_comb begin
        pol_d   = pol_q;
        sel_pol = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            if (cfg_we && cfg_dev == dev_e'(i)) pol_d.pol[i] = cfg_bit;
            if (act_dev == dev_e'(i))           sel_pol      = pol_q.pol[i];
        end
        ready    = (bus_wait != sel_pol);
        mismatch = 1'b0;
        for (int i = 0; i < RAM_IDX; i++) begin
            if (pol_q.pol[i] != pol_q.pol[RAM_IDX]) mismatch = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pol_q.pol <= RST_POL;
        else     pol_q     <= pol_d;
    end

    // R6: polarity bits change only through configuration writes
    a_r6_pol_stable: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(pol_q.pol));
endmodule

// File: rtl/memsel_router.sv
`timescale 1ns/1ps
module memsel_router
    import memsel_pkg::*;
#(
    parameter int AW      = 23,
    parameter int DW      = 16,
    parameter int LEN_W   = 6,
    parameter int POL_BIT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_req,
    input  logic             host_we,
    input  logic             host_cfg,
    input  logic [AW-1:0]    host_addr,
    input  logic [LEN_W-1:0] host_len,
    input  logic [DW-1:0]    host_wdata,
    output logic             host_ack,
    output logic             host_err,
    output logic             host_beat,
    output logic             host_ready,
    output logic             cfg_mismatch,
    output logic [1:0]       fl_ce_n,
    output logic [1:0]       fl_oe_n,
    output logic             ram_ce_n,
    output logic             ram_oe_n,
    output logic             bus_we_n,
    output logic             bus_cfg,
    output logic [AW-2:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic             bus_wait,
    output logic             fl_rst_n
);
    localparam int CW = 8;

    typedef struct packed {
        st_e              st;
        dev_e             dev;
        logic [AW-1:0]    addr;
        logic [LEN_W-1:0] remain;
        logic             rd;
        logic             cfg;
        logic [DW-1:0]    wdata;
        logic [NDEV-1:0]  ce_n;
        logic [NDEV-1:0]  oe_n;
        logic             we_n;
        logic             ack;
        logic             err;
        logic             rst_n;
    } rtr_t;

    localparam rtr_t RTR_RST = '{
        st: ST_IDLE, dev: DEV_F1, addr: '0, remain: '0, rd: 1'b0, cfg: 1'b0,
        wdata: '0, ce_n: '1, oe_n: '1, we_n: 1'b1, ack: 1'b0, err: 1'b0,
        rst_n: 1'b0
    };

    rtr_t rtr_d, rtr_q;

    dev_e          host_dev, cur_dev, nxt_dev;
    logic [AW-1:0] addr_inc;
    logic          accept, fl_wr, cfg_wr, reject;
    logic          read_act, wn_ready, beat;

    assign addr_inc = rtr_q.addr + AW'(1);

    memsel_decode #(.AW(AW)) i_dec_host (.addr(host_addr),   .dev(host_dev));
    memsel_decode #(.AW(AW)) i_dec_cur  (.addr(rtr_q.addr),  .dev(cur_dev));
    memsel_decode #(.AW(AW)) i_dec_nxt  (.addr(addr_inc),    .dev(nxt_dev));

    assign accept = (rtr_q.st == ST_IDLE) && host_req && !rtr_q.ack;
    assign fl_wr  = accept && host_we && !host_cfg && (host_dev != DEV_RAM);
    assign cfg_wr = accept && host_we && host_cfg;

    memsel_cmd_guard #(.CW(CW)) i_guard (
        .clk    (clk),
        .rst    (rst),
        .fl_wr  (fl_wr),
        .die    (host_dev == DEV_F2),
        .code   (host_wdata[CW-1:0]),
        .reject (reject)
    );

    memsel_wait_norm i_wait (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_wr),
        .cfg_dev  (host_dev),
        .cfg_bit  (host_wdata[POL_BIT]),
        .act_dev  (rtr_q.dev),
        .bus_wait (bus_wait),
        .ready    (wn_ready),
        .mismatch (cfg_mismatch)
    );

    assign read_act = (rtr_q.st == ST_ACT) && rtr_q.rd;
    assign beat     = read_act && wn_ready;

    always_comb begin
        rtr_d       = rtr_q;
        rtr_d.ack   = 1'b0;
        rtr_d.err   = 1'b0;
        rtr_d.rst_n = 1'b1;
        case (rtr_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (fl_wr && reject) begin
                        rtr_d.ack = 1'b1;
                        rtr_d.err = 1'b1;
                    end else begin
                        rtr_d.st     = ST_ACT;
                        rtr_d.dev    = host_dev;
                        rtr_d.addr   = host_addr;
                        rtr_d.remain = (host_len == '0) ? LEN_W'(1) : host_len;
                        rtr_d.rd     = !host_we;
                        rtr_d.cfg    = cfg_wr;
                        rtr_d.wdata  = host_wdata;
                    end
                end
            end
            ST_ACT: begin
                if (!rtr_q.rd) begin
                    rtr_d.st  = ST_IDLE;
                    rtr_d.ack = 1'b1;
                end else if (beat) begin
                    if (rtr_q.remain == LEN_W'(1)) begin
                        rtr_d.st  = ST_IDLE;
                        rtr_d.ack = 1'b1;
                    end else begin
                        rtr_d.addr   = addr_inc;
                        rtr_d.remain = rtr_q.remain - LEN_W'(1);
                        if (nxt_dev != rtr_q.dev) rtr_d.st = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                rtr_d.st  = ST_ACT;
                rtr_d.dev = cur_dev;
            end
            default: rtr_d.st = ST_IDLE;
        endcase

        if (rtr_d.st == ST_ACT) begin
            rtr_d.ce_n = ~dev_onehot(rtr_d.dev);
            rtr_d.oe_n = rtr_d.rd ? ~dev_onehot(rtr_d.dev) : '1;
            rtr_d.we_n = rtr_d.rd;
        end else begin
            rtr_d.ce_n = '1;
            rtr_d.oe_n = '1;
            rtr_d.we_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rtr_q <= RTR_RST;
        else     rtr_q <= rtr_d;
    end

    assign fl_ce_n    = rtr_q.ce_n[1:0];
    assign ram_ce_n   = rtr_q.ce_n[2];
    assign fl_oe_n    = rtr_q.oe_n[1:0];
    assign ram_oe_n   = rtr_q.oe_n[2];
    assign bus_we_n   = rtr_q.we_n;
    assign bus_cfg    = rtr_q.cfg && !rtr_q.we_n;
    assign bus_addr   = rtr_q.addr[AW-2:0];
    assign bus_wdata  = rtr_q.wdata;
    assign host_ack   = rtr_q.ack;
    assign host_err   = rtr_q.err;
    assign host_beat  = beat;
    assign host_ready = read_act ? wn_ready : 1'b1;
    assign fl_rst_n   = rtr_q.rst_n;

    logic [NDEV-1:0] ce_vec, oe_vec;
    assign ce_vec = {ram_ce_n, fl_ce_n};
    assign oe_vec = {ram_oe_n, fl_oe_n};

    a_r2_single_ce: assert property (@(posedge clk) disable iff (rst)
        $countones(~ce_vec) <= 1);

    a_r4_gap_on_switch: assert property (@(posedge clk) disable iff (rst)
        (!(&ce_vec) && !(&$past(ce_vec))) |-> (ce_vec == $past(ce_vec)));

    a_r3_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        ((~oe_vec & ce_vec) == '0));

    a_r3_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    a_r5_err_with_ack: assert property (@(posedge clk) disable iff (rst)
        host_err |-> host_ack);

    a_r9_ready_outside_read: assert property (@(posedge clk) disable iff (rst)
        (&oe_vec) |-> (host_ready && !host_beat));

    a_r10_quiet_in_flash_reset: assert property (@(posedge clk) disable iff (rst)
        !fl_rst_n |-> ((&ce_vec) && bus_we_n));
endmodule

// File: tb/test_memsel_router.sv
`timescale 1ns/1ps
module test_memsel_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0, host_cfg = 1'b0;
    logic [22:0] host_addr = '0;
    logic [5:0]  host_len = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ack, host_err, host_beat, host_ready, cfg_mismatch;
    logic [1:0]  fl_ce_n, fl_oe_n;
    logic        ram_ce_n, ram_oe_n, bus_we_n, bus_cfg, fl_rst_n;
    logic [21:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_wait = 1'b0;

    always #2.5 clk = ~clk;

    memsel_router i_memsel_router (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_cfg(host_cfg), .host_addr(host_addr), .host_len(host_len),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_err(host_err),
        .host_beat(host_beat), .host_ready(host_ready),
        .cfg_mismatch(cfg_mismatch), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .bus_we_n(bus_we_n),
        .bus_cfg(bus_cfg), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wait(bus_wait), .fl_rst_n(fl_rst_n)
    );

    int   total = 0;
    int   bad   = 0;
    logic [2:0] pol_m = 3'b100;
    logic arm_m = 1'b0;
    logic armdie_m = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int dev_of(input logic [22:0] a);
        if (a[22]) return 2;
        if (a[21]) return 1;
        return 0;
    endfunction

    function automatic int ce_dev();
        if (!fl_ce_n[0]) return 0;
        if (!fl_ce_n[1]) return 1;
        if (!ram_ce_n)   return 2;
        return 3;
    endfunction

    function automatic int ce_lows();
        return int'(!fl_ce_n[0]) + int'(!fl_ce_n[1]) + int'(!ram_ce_n);
    endfunction

    function automatic bit exp_mismatch();
        return (pol_m[0] != pol_m[2]) || (pol_m[1] != pol_m[2]);
    endfunction

    task automatic do_write(input logic [22:0] a, input logic [15:0] d, input bit cfg);
        int  dv     = dev_of(a);
        bit  experr = !cfg && dv != 2 && arm_m && (armdie_m != dv[0]);
        int  cecnt  = 0;
        int  guard  = 0;
        if (cfg) pol_m[dv] = d[10];
        else if (dv != 2) begin
            if (arm_m) arm_m = 1'b0;
            else if (d[7:0] == 8'h40 || d[7:0] == 8'h20) begin
                arm_m = 1'b1; armdie_m = dv[0];
            end
        end
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_cfg = cfg;
        host_addr = a; host_wdata = d; host_len = '0;
        forever begin
            @(negedge clk);
            bus_wait = 1'($urandom);
            #1;
            if (ce_lows() > 1) chk(0, "R2", "enables low", ce_lows(), 1);
            if (!host_ready) chk(0, "R9", "ready during write", host_ready, 1);
            if (ce_dev() != 3) begin
                cecnt++;
                chk(ce_dev() == dv, "R1", "write device", ce_dev(), dv);
                chk(!bus_we_n && fl_oe_n == 2'b11 && ram_oe_n, "R3", "write strobes",
                    {bus_we_n, fl_oe_n, ram_oe_n}, 4'b0111);
                chk(bus_cfg == cfg, "R6", "cfg strobe", bus_cfg, cfg);
                chk(bus_wdata == d, "R3", "write data", bus_wdata, d);
            end
            if (host_ack) begin
                chk(host_err == experr, "R5", "error flag", host_err, experr);
                chk(cecnt == (experr ? 0 : 1), "R5", "bus cycles", cecnt, experr ? 0 : 1);
                host_req = 1'b0;
                break;
            end
            guard++;
            if (guard > 50) begin
                chk(0, "R3", "write never acked", guard, 0);
                host_req = 1'b0;
                break;
            end
        end
        if (cfg) chk(cfg_mismatch == exp_mismatch(), "R7", "mismatch",
                     cfg_mismatch, exp_mismatch());
    endtask

    task automatic do_read(input logic [22:0] a, input logic [5:0] len);
        int          nw      = (len == 0) ? 1 : int'(len);
        int          expsegs = 1;
        int          segs    = 0;
        int          beats   = 0;
        int          last    = 3;
        int          prev    = 3;
        int          guard   = 0;
        logic [22:0] ea      = a;
        for (int i = 1; i < nw; i++)
            if (dev_of(a + 23'(i)) != dev_of(a + 23'(i - 1))) expsegs++;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_cfg = 1'b0;
        host_addr = a; host_len = len;
        forever begin
            int dv;
            bit er;
            @(negedge clk);
            bus_wait = 1'($urandom);
            #1;
            dv = ce_dev();
            if (ce_lows() > 1) chk(0, "R2", "enables low", ce_lows(), 1);
            if (dv != 3) begin
                if (dv != last) begin
                    segs++;
                    if (last != 3 && prev != 3) chk(0, "R4", "no idle gap", prev, 3);
                    last = dv;
                end
                chk(dv == dev_of(ea), "R4", "read device", dv, dev_of(ea));
                chk(bus_addr == ea[21:0], "R4", "bus address", bus_addr, ea[21:0]);
                chk({ram_oe_n, fl_oe_n} == {ram_ce_n, fl_ce_n} && bus_we_n, "R3",
                    "read strobes", {ram_oe_n, fl_oe_n}, {ram_ce_n, fl_ce_n});
                er = (bus_wait != pol_m[dv]);
                chk(host_ready == er && host_beat == er, "R8", "ready/beat",
                    {host_ready, host_beat}, {er, er});
                if (er) begin beats++; ea = ea + 23'(1); end
            end else begin
                chk(host_ready && !host_beat, "R9", "ready outside data",
                    {host_ready, host_beat}, 2'b10);
            end
            prev = dv;
            if (host_ack) begin
                chk(beats == nw, "R3", "words read", beats, nw);
                chk(segs == expsegs, "R4", "segments", segs, expsegs);
                chk(!host_err, "R5", "read error", host_err, 0);
                host_req = 1'b0;
                break;
            end
            guard++;
            if (guard > 400) begin
                chk(0, "R8", "read never acked", guard, 0);
                host_req = 1'b0;
                break;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(!fl_rst_n, "R10", "flash reset low", fl_rst_n, 0);
        chk(fl_ce_n == 2'b11 && ram_ce_n && fl_oe_n == 2'b11 && ram_oe_n && bus_we_n,
            "R10", "enables in reset", {fl_ce_n, ram_ce_n, fl_oe_n, ram_oe_n, bus_we_n},
            7'h7f);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(fl_rst_n, "R10", "flash reset released", fl_rst_n, 1);
        chk(cfg_mismatch, "R7", "mismatch after reset", cfg_mismatch, 1);

        // Directed reads: plain, die edge, flash/RAM edge, top wrap, zero length
        do_read(23'h000010, 6'd4);
        do_read(23'h1FFFFE, 6'd4);
        do_read(23'h3FFFFF, 6'd3);
        do_read(23'h7FFFFF, 6'd2);
        do_read(23'h400100, 6'd0);

        // Directed command pairs
        do_write(23'h000100, 16'h0040, 1'b0);   // setup on die 0
        do_write(23'h200100, 16'h1234, 1'b0);   // other die: refused
        do_write(23'h200100, 16'h5678, 1'b0);   // released: issued
        do_write(23'h200200, 16'h0020, 1'b0);   // setup on die 1
        do_write(23'h200200, 16'h00D0, 1'b0);   // same die: issued
        do_write(23'h500000, 16'h0040, 1'b0);   // RAM write, no arming

        // Directed polarity changes
        do_write(23'h400000, 16'h0000, 1'b1);
        do_read(23'h400010, 6'd5);
        do_write(23'h200000, 16'h0400, 1'b1);
        do_read(23'h1FFFFD, 6'd6);
        do_write(23'h000000, 16'h0400, 1'b1);
        do_write(23'h400000, 16'h0400, 1'b1);
        do_read(23'h3FFFFC, 6'd8);

        // Random mix, biased toward boundaries
        for (int k = 0; k < 120; k++) begin
            int          op   = $urandom % 10;
            int          sel  = $urandom % 4;
            logic [22:0] base;
            logic [15:0] d;
            case (sel)
                0: base = 23'h200000;
                1: base = 23'h400000;
                2: base = 23'h000000;
                default: base = 23'($urandom);
            endcase
            base = base - 23'($urandom % 6);
            if (op < 5) begin
                do_read(base, 6'(1 + $urandom % 8));
            end else if (op < 8) begin
                d = 16'($urandom);
                if ($urandom % 2) d[7:0] = ($urandom % 2) ? 8'h40 : 8'h20;
                do_write(base, d, 1'b0);
            end else begin
                d = 16'($urandom);
                do_write(base, d, 1'b1);
            end
        end

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule